// File: doc/BRIEF.md
# Dual-Clock First-Word Fall-Through FIFO

This block is a small queue that carries 5-bit words between two unrelated clock domains. The producer raises `load` and is sampled on the rising edge of `wclk`. The consumer raises `unload` and is sampled on the rising edge of `rclk`. The oldest stored word is always driven on `q` without any read request, so the consumer sees the head word as soon as `empty_n` goes high. An `unload` only advances to the next word.

Four active-low flags report the fill level. `full_n` and `nfull_n` are computed on the write side, and `empty_n` and `nempty_n` on the read side. Each side compares its own pointer with a Gray-coded copy of the far pointer, which passes through two flip-flops. A flag may therefore lag the true fill level, but it never claims room or data that is not there. `arst_n` asserts asynchronously, and its release is synchronized separately into each domain. While `oe` is low, `q` floats.

Top module: `dcfifo_ft`

## Requirements
- R1: Words leave on `q` in the order they were loaded, bit for bit and not inverted.
- R2: A `load` while the write side sees 16 words held changes neither the stored contents nor the fill level.
- R3: An `unload` while the read side sees no words held changes neither `q` nor the fill level.
- R4: Once settled, `full_n` is low exactly when 16 words are held and `nfull_n` is low exactly when 15 words are held.
- R5: Once settled, `empty_n` is low exactly when 0 words are held and `nempty_n` is low exactly when 1 word is held.
- R6: Reset empties the queue, drives `empty_n` low, and drives `full_n`, `nfull_n` and `nempty_n` high. Reset does not define `q`.
- R7: The first word loaded into an empty queue appears on `q` without any `unload`.
- R8: While `oe` is low, `q` is high impedance and all four flags are unaffected.
- R9: Each side's count of words held never exceeds 16. Each Gray pointer changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Store `din` on this `wclk` edge |
| din | input | 5 | Write data |
| unload | input | 1 | Advance to the next word on this `rclk` edge |
| oe | input | 1 | Drive `q` when high; float `q` when low |
| q | output | 5 | Head word of the queue |
| full_n | output | 1 | Low when 16 words are held |
| nfull_n | output | 1 | Low when 15 words are held |
| empty_n | output | 1 | Low when no words are held |
| nempty_n | output | 1 | Low when one word is held |

## Verification
The write-side flags change on the same `wclk` edge that accepts a load. The read side sees that load only after two `rclk` edges, and `q` and `empty_n` change then. A read is reflected in `full_n` two `wclk` edges later, by the same path in the other direction. The bench therefore applies one operation at a time and then waits three edges of each clock, so that every flag and `q` has settled before it compares them with a queue model. Fills to each level from 0 to 16, loads while full, unloads while empty, a reset in mid-fill and toggling `oe` are all covered.

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int W  = 5,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         arst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         unload,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         full_n,
  output logic         nfull_n,
  output logic         empty_n,
  output logic         nempty_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [1 << AW];
  logic [1:0]    wrs, rrs;
  logic          wrst_n, rrst_n;
  logic [PW-1:0] wbin, wg, rbin, rg;
  logic [PW-1:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic [PW-1:0] wcnt, rcnt, wbin_nx, rbin_nx;
  logic          wr_ok, rd_ok;

  always_ff @(posedge wclk or negedge arst_n)
    if (!arst_n) wrs <= '0;
    else         wrs <= {wrs[0], 1'b1};
  always_ff @(posedge rclk or negedge arst_n)
    if (!arst_n) rrs <= '0;
    else         rrs <= {rrs[0], 1'b1};
  assign wrst_n = wrs[1];
  assign rrst_n = rrs[1];

  assign wcnt    = wbin - g2b(rg_w2);
  assign wr_ok   = load && (wcnt != DEPTH);
  assign wbin_nx = wbin + PW'(wr_ok);

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wg <= '0; rg_w1 <= '0; rg_w2 <= '0;
    end else begin
      wbin  <= wbin_nx;
      wg    <= wbin_nx ^ (wbin_nx >> 1);
      rg_w1 <= rg;
      rg_w2 <= rg_w1;
    end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= din;

  assign rcnt    = g2b(wg_r2) - rbin;
  assign rd_ok   = unload && (rcnt != '0);
  assign rbin_nx = rbin + PW'(rd_ok);

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rg <= '0; wg_r1 <= '0; wg_r2 <= '0;
    end else begin
      rbin  <= rbin_nx;
      rg    <= rbin_nx ^ (rbin_nx >> 1);
      wg_r1 <= wg;
      wg_r2 <= wg_r1;
    end

  assign full_n   = (wcnt != DEPTH);
  assign nfull_n  = (wcnt != DEPTH - 1'b1);
  assign empty_n  = (rcnt != '0);
  assign nempty_n = (rcnt != PW'(1));
  assign q        = oe ? mem[rbin[AW-1:0]] : 'z;

  // R2
  full_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (load && !full_n) |=> (wbin == $past(wbin)));
  // R3
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (unload && !empty_n) |=> (rbin == $past(rbin)));
  // R4
  wflag_excl_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0({!full_n, !nfull_n}));
  // R5
  rflag_excl_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $onehot0({!empty_n, !nempty_n}));
  // R9
  wcount_max_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcnt <= DEPTH);
  // R9
  rcount_max_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rcnt <= DEPTH);
  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wg ^ $past(wg)) <= 1);
  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rg ^ $past(rg)) <= 1);
endmodule

// File: tb/sim_dcfifo_ft.sv
`timescale 1ns/100ps
module sim_dcfifo_ft;
  logic wclk = 0, rclk = 0, arst_n = 0, load = 0, unload = 0, oe = 1;
  logic [4:0] din = '0;
  tri0  [4:0] qb;
  logic full_n, nfull_n, empty_n, nempty_n;
  int total = 0, bad = 0;
  int unsigned qm[$];
  int seq = 0;

  always #2.5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  dcfifo_ft u0 (.wclk(wclk), .rclk(rclk), .arst_n(arst_n), .load(load), .din(din),
                .unload(unload), .oe(oe), .q(qb), .full_n(full_n), .nfull_n(nfull_n),
                .empty_n(empty_n), .nempty_n(nempty_n));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle;
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    #1;
  endtask

  task automatic verify;
    int n = qm.size();
    chk("R4 full_n", int'(full_n), int'(n != 16));
    chk("R4 nfull_n", int'(nfull_n), int'(n != 15));
    chk("R5 empty_n", int'(empty_n), int'(n != 0));
    chk("R5 nempty_n", int'(nempty_n), int'(n != 1));
    if (n > 0) chk("R1 R7 head word", int'(qb), int'(qm[0]));
  endtask

  task automatic push;
    logic [4:0] d = 5'((seq * 7 + 3) % 31 + 1);
    seq++;
    @(negedge wclk); load = 1; din = d;
    @(negedge wclk); load = 0;
    if (qm.size() < 16) qm.push_back(int'(d));
    settle();
    verify();
  endtask

  task automatic pop;
    @(negedge rclk); unload = 1;
    @(negedge rclk); unload = 0;
    if (qm.size() > 0) void'(qm.pop_front());
    settle();
    verify();
  endtask

  task automatic do_reset;
    arst_n = 0;
    qm.delete();
    #20;
    chk("R6 empty_n in reset", int'(empty_n), 0);
    chk("R6 full_n in reset", int'(full_n), 1);
    chk("R6 nfull_n in reset", int'(nfull_n), 1);
    chk("R6 nempty_n in reset", int'(nempty_n), 1);
    arst_n = 1;
    settle();
    verify();
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R7 then R4: fill to the top
    for (int i = 0; i < 16; i++) push();
    // R2: loads while full are dropped
    push(); push();
    chk("R2 level stays 16", int'(full_n), 0);
    // R8: floated output, flags untouched
    @(negedge wclk); oe = 0; #1;
    chk("R8 q floats", int'(qb), 0);
    chk("R8 full_n kept", int'(full_n), 0);
    chk("R8 empty_n kept", int'(empty_n), 1);
    @(negedge wclk); oe = 1; #1;
    chk("R8 q restored", int'(qb), int'(qm[0]));
    // R1: drain in order
    for (int i = 0; i < 16; i++) pop();
    // R3: unloads while empty are dropped
    pop(); pop();
    push();
    chk("R3 word after empty unloads", int'(qb), int'(qm[0]));
    pop();
    // sweep of every fill level
    for (int n = 1; n <= 16; n++) begin
      for (int i = 0; i < n; i++) push();
      for (int i = 0; i < n; i++) pop();
    end
    // R6: reset in mid-fill, then R7 again
    for (int i = 0; i < 5; i++) push();
    do_reset();
    push();
    chk("R7 first after reset", int'(qb), int'(qm[0]));
    pop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule